// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Code Register Interface

This block holds the digital codes for a four-channel, 12-bit voltage-output converter. A host reaches it over a parallel bus with these signals: an active-low select, a read/write strobe, a two-bit channel address and a 12-bit data path. The data path is split here into an inbound word, an outbound word and a drive enable for the external bidirectional pad. Every channel has two registers. The input register is staged by the host. The output register holds the code that goes to the converter. An active-low load strobe copies all four input registers into the output registers in the same cycle.

There are two ways to use it. In double-buffer mode the host writes the channels one after another with the load strobe high, then pulses load once so that all four outputs change together. In single-buffer mode the host holds load low, and each write reaches its output register at once. The host can read back the staged input register of any channel. An active-low reset returns both register banks to a default code chosen at build time: mid-scale 0x800 or zero-scale 0x000.

All bus inputs pass through a two-flop synchroniser into the system clock domain. A write is committed on the rising edge of the select. It uses the address and data that were present just before that edge, so the bus may change at the same moment the select rises.

Top module: `quad_dac_regif`

## Requirements
- R1: While reset is low, and after it, until a load moves new data, every channel output reads the reset code. The reset code is 0x800 when RESET_MID=1 (the default) and 0x000 when RESET_MID=0. The drive enable is low during reset.
- R2: A write (select low, rw low, then select rising) stores the data word in the input register of the addressed channel: 00=A, 01=B, 10=C, 11=D. Channel k appears on code_o bits [12k+11:12k].
- R3: A write made while load is high leaves all four channel outputs unchanged.
- R4: While load is low, all four output registers take the values of their input registers in the same cycle.
- R5: With load held low (single-buffer mode), a written code appears on its channel output within five clocks of the select rising. If a write and a load fall in the same cycle, the new word is the one that reaches the output.
- R6: While select is low and rw is high, the drive enable is high and the outbound word equals the input register of the addressed channel.
- R7: The drive enable is low whenever select is high or rw is low.
- R8: Reset also sets every input register to the reset code. A load after reset, or a readback after reset, returns the reset code and never data staged before reset.
- R9: A write takes no effect while the select is still low. It commits only after the select rises.
- R10: Address and data that change at the same moment the select rises have no effect. The committed write uses the values held while the select was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low chip select |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 2 | Channel address |
| bus_din | input | 12 | Inbound data word from the pad |
| bus_dout | output | 12 | Outbound readback word to the pad |
| bus_doe | output | 1 | Pad drive enable; low means high impedance |
| load_n | input | 1 | Active-low transfer of input to output registers |
| code_o | output | 48 | Four channel output codes, channel A in the low bits |

## Verification
The bench sweeps many code patterns through all four channels, including all-zeros and all-ones. It checks that staged writes never leak to the outputs before a load. A design that copied data on every write would fail the double-buffer checks. It holds the select low for many cycles to catch a design that commits on the level instead of the rising edge. It also changes address and data at the same moment the select rises, which exposes synchroniser stages that are not aligned. A design that wrote the late values would corrupt the wrong channel. The bench loads and reads back just after reset to catch input registers that keep stale data, and it drives write and load together in single-buffer mode to confirm that the new word is the one that wins.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   // Default code applied by reset: half scale or zero scale.
   function automatic logic [31:0] reset_code(input int unsigned width, input bit mid);
      logic [31:0] v;
      v = '0;
      if (mid) v[width-1] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qdac_sync needs at least two stages");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= IDLE;
         else if (s == 0) pipe[s] <= d;
         else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/qdac_busport.sv
module qdac_busport #(
   parameter int unsigned AW = 2,
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n_s,
   input  logic          rd_s,
   input  logic [AW-1:0] addr_s,
   input  logic [DW-1:0] data_s,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr
);

   // One extra stage so the word seen with the select still low is kept.
   logic          sel_n_d;
   logic          rd_d;
   logic [AW-1:0] addr_d;
   logic [DW-1:0] data_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_n_d <= 1'b1;
         rd_d    <= 1'b1;
         addr_d  <= '0;
         data_d  <= '0;
      end else begin
         sel_n_d <= sel_n_s;
         rd_d    <= rd_s;
         addr_d  <= addr_s;
         data_d  <= data_s;
      end
   end

   assign wr_en   = sel_n_s && !sel_n_d && !rd_d;
   assign wr_addr = addr_d;
   assign wr_data = data_d;
   assign rd_en   = !sel_n_s && rd_s;
   assign rd_addr = addr_s;

   a_r9_commit_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
   parameter int unsigned  DW       = 12,
   parameter logic [DW-1:0] RST_CODE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          load_en,
   output logic [DW-1:0] in_q,
   output logic [DW-1:0] out_q
);

   logic [DW-1:0] in_next;

   assign in_next = wr_en ? wr_data : in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= RST_CODE;
         out_q <= RST_CODE;
      end else begin
         in_q <= in_next;
         if (load_en) out_q <= in_next;
      end
   end

   a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(out_q));

   a_r4_load_copies_input: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !wr_en) |=> out_q == $past(in_q));

   a_r5_new_word_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && wr_en) |=> out_q == $past(wr_data));

endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif #(
   parameter int unsigned NCH       = 4,
   parameter int unsigned DW        = 12,
   parameter int unsigned SYNC_FF   = 2,
   parameter bit          RESET_MID = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel_n,
   input  logic                  bus_rd,
   input  logic [$clog2(NCH)-1:0] bus_addr,
   input  logic [DW-1:0]         bus_din,
   output logic [DW-1:0]         bus_dout,
   output logic                  bus_doe,
   input  logic                  load_n,
   output logic [NCH*DW-1:0]     code_o
);

   localparam int unsigned AW = $clog2(NCH);
   localparam int unsigned SW = 3 + AW + DW;
   localparam logic [DW-1:0] RST_CODE = DW'(qdac_pkg::reset_code(DW, RESET_MID));
   localparam logic [SW-1:0] SYNC_IDLE = {3'b111, {(AW+DW){1'b0}}};

   if (NCH < 2 || (1 << AW) != NCH) begin : g_bad_nch
      $error("NCH must be a power of two of at least 2");
   end
   if (DW < 2 || DW > 32) begin : g_bad_dw
      $error("DW must lie in 2..32");
   end

   logic [SW-1:0] raw_bus, sync_bus;
   logic          sel_n_s, rd_s, load_n_s;
   logic [AW-1:0] addr_s;
   logic [DW-1:0] data_s;

   assign raw_bus = {bus_sel_n, bus_rd, load_n, bus_addr, bus_din};

   qdac_sync #(.W(SW), .STAGES(SYNC_FF), .IDLE(SYNC_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
   );

   assign {sel_n_s, rd_s, load_n_s, addr_s, data_s} = sync_bus;

   logic          wr_en, rd_en;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [DW-1:0] wr_data;

   qdac_busport #(.AW(AW), .DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .sel_n_s(sel_n_s), .rd_s(rd_s), .addr_s(addr_s), .data_s(data_s),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr)
   );

   logic [NCH-1:0] wr_vec;
   logic [DW-1:0]  in_arr [NCH];

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      assign wr_vec[k] = wr_en && (wr_addr == AW'(k));
      qdac_channel #(.DW(DW), .RST_CODE(RST_CODE)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .wr_en(wr_vec[k]), .wr_data(wr_data),
         .load_en(!load_n_s),
         .in_q(in_arr[k]), .out_q(code_o[k*DW +: DW])
      );
   end

   assign bus_doe  = rd_en;
   assign bus_dout = rd_en ? in_arr[rd_addr] : '0;

   a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_vec));

   a_r7_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !bus_doe);

endmodule

// File: tb/quad_dac_regif_tb.sv
module quad_dac_regif_tb;

   localparam int DW = 12;
   localparam logic [DW-1:0] RC = 12'h800;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1;
   logic          rd = 1'b1;
   logic [1:0]    addr = '0;
   logic [DW-1:0] din = '0;
   logic          load_n = 1'b1;
   logic [DW-1:0] dout;
   logic          doe;
   logic [4*DW-1:0] code;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [DW-1:0] exp_in [4];
   logic [DW-1:0] exp_out [4];

   always #5 clk = ~clk;

   quad_dac_regif u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_rd(rd),
      .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_doe(doe),
      .load_n(load_n), .code_o(code)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         $display("FAIL watchdog: run hung, got cycle %0d expected finish", cyc);
         bad = bad + 1;
         total = total + 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_outs(input string tag);
      for (int k = 0; k < 4; k++) chk(tag, code[k*DW +: DW], exp_out[k]);
   endtask

   task automatic bus_write(input logic [1:0] ch, input logic [DW-1:0] v);
      @(negedge clk);
      sel_n = 1'b0; rd = 1'b0; addr = ch; din = v;
      wait_n(4);
      chk("R7 no drive while writing", doe, 1'b0);
      sel_n = 1'b1;
      wait_n(5);
      rd = 1'b1;
      exp_in[ch] = v;
      if (!load_n) exp_out[ch] = v;
   endtask

   task automatic bus_read(input logic [1:0] ch, input string tag);
      @(negedge clk);
      sel_n = 1'b0; rd = 1'b1; addr = ch;
      wait_n(4);
      chk({tag, " R6 drive enable"}, doe, 1'b1);
      chk({tag, " R6 readback"}, dout, exp_in[ch]);
      sel_n = 1'b1;
      wait_n(4);
      chk("R7 released after read", doe, 1'b0);
   endtask

   task automatic pulse_load();
      @(negedge clk);
      load_n = 1'b0;
      wait_n(4);
      load_n = 1'b1;
      wait_n(4);
      for (int k = 0; k < 4; k++) exp_out[k] = exp_in[k];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wait_n(2);
      for (int k = 0; k < 4; k++) begin exp_in[k] = RC; exp_out[k] = RC; end
      check_outs("R1 outputs in reset");
      chk("R1 no drive in reset", doe, 1'b0);
      rst_n = 1'b1;
      wait_n(3);
   endtask

   initial begin
      logic [DW-1:0] v;
      for (int k = 0; k < 4; k++) begin exp_in[k] = RC; exp_out[k] = RC; end
      do_reset();
      check_outs("R1 outputs after reset");

      // R8: load and readback just after reset give the reset code
      pulse_load();
      check_outs("R8 load after reset");
      for (int k = 0; k < 4; k++) bus_read(2'(k), "R8");

      // R2 R3 R4: double-buffer sweep
      for (int it = 0; it < 24; it++) begin
         for (int k = 0; k < 4; k++) begin
            v = DW'((it * 12'h1a7 + k * 12'h2e5 + (it * it) * 3) & 12'hfff);
            if (it == 0) v = 12'h000;
            if (it == 1) v = 12'hfff;
            bus_write(2'(k), v);
            check_outs("R3 outputs held while load high");
         end
         for (int k = 0; k < 4; k++) bus_read(2'(k), "R2");
         pulse_load();
         check_outs("R4 all outputs loaded together");
      end

      // R7: select high with read level does not drive
      @(negedge clk); sel_n = 1'b1; rd = 1'b1;
      wait_n(4);
      chk("R7 idle bus no drive", doe, 1'b0);

      // R5: single-buffer mode
      @(negedge clk); load_n = 1'b0;
      wait_n(4);
      for (int it = 0; it < 8; it++) begin
         for (int k = 0; k < 4; k++) begin
            v = DW'((it * 12'h31d + k * 12'h0c9 + 12'h055) & 12'hfff);
            bus_write(2'(k), v);
            check_outs("R5 single-buffer output follows write");
         end
      end

      // R9: holding select low does not commit
      @(negedge clk);
      sel_n = 1'b0; rd = 1'b0; addr = 2'd2; din = 12'h5a5;
      wait_n(12);
      check_outs("R9 no commit while select low");
      sel_n = 1'b1;
      wait_n(5);
      rd = 1'b1;
      exp_in[2] = 12'h5a5; exp_out[2] = 12'h5a5;
      check_outs("R9 commit after select rise");

      // R10: address and data change together with select rise
      @(negedge clk);
      sel_n = 1'b0; rd = 1'b0; addr = 2'd1; din = 12'h3c3;
      wait_n(4);
      sel_n = 1'b1; addr = 2'd3; din = 12'hbad;
      wait_n(5);
      rd = 1'b1;
      exp_in[1] = 12'h3c3; exp_out[1] = 12'h3c3;
      check_outs("R10 late bus changes ignored");
      @(negedge clk); load_n = 1'b1;
      wait_n(3);
      for (int k = 0; k < 4; k++) bus_read(2'(k), "R10");

      // R1 R8: reset in mid operation clears both banks
      bus_write(2'd0, 12'h123);
      do_reset();
      check_outs("R1 outputs after second reset");
      for (int k = 0; k < 4; k++) bus_read(2'(k), "R8 after reset");
      pulse_load();
      check_outs("R8 no stale data after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule